// File: doc/BRIEF.md
# Dual-Capture Timer with Toggle Output

This block is a 16-bit up-counter with a compare register, two capture registers and an output flip-flop that can be inverted by a compare match or by a capture. The counter advances on one of two sources: a one-cycle tick from an external prescaler, or rising edges on an external count pin. The count pin, a trigger pin and a gate signal from a companion interval timer are each resynchronised through a two-flop chain and turned into one-cycle edge pulses in the system clock domain.

The block has two main uses. For frequency measurement, the counter runs from the count pin while the gate's rising edge captures into register 0 and its falling edge captures into register 1. Software then divides the modulo-2^16 difference by the gate high time. For example, 100 counts over a 0.5 s gate gives 200 Hz. For a one-shot pulse, a trigger edge captures the count and inverts the output. The later compare match inverts it back, so the pulse lasts for the compare value minus the captured count.

Configuration uses a small write/read register port. Reads are registered with one cycle of latency.

Top module: `dcap_timer`

## Requirements
- R1: While the run bit is 1, the 16-bit counter increases by exactly one on each enabled count step. While the run bit is 0, it holds its value.
- R2: With the source bit at 0, each cycle with `tick_i` high is one count step. With the source bit at 1, `tick_i` is ignored and each rising edge of `cnt_pin_i` is one step. The edge takes effect three clock edges after the pin changes.
- R3: Capture mode 3 (binary 11) selects the gate as the capture source. A gate rising edge copies the counter into capture 0, and a falling edge copies it into capture 1. Each capture pulses its own flag (`irq_cap0_o` or `irq_cap1_o`) for one cycle.
- R4: Capture mode 1 copies the counter into capture 0 on a trigger rising edge and into capture 1 on a trigger falling edge. Capture mode 2 captures only on the trigger rising edge, into capture 0.
- R5: In capture mode 0, gate and trigger edges change neither capture register and raise no capture flag.
- R6: A count step that brings the counter to the compare value inverts the output and pulses `irq_cmp_o` for one cycle.
- R7: When its enable bit is 1, a capture into register 0 inverts the output. Likewise, a capture into register 1 inverts the output when its own enable bit is 1. With the enable at 0, the capture leaves the output unchanged.
- R8: With initial level 0, capture mode 2 and the capture-0 toggle enabled, a trigger rising edge drives the output high. The output stays high for exactly (compare − captured count) count steps.
- R9: The counter wraps from 0xFFFF to 0x0000, so a gate window containing one wrap yields a correct modulo-2^16 difference between the captures.
- R10: Writing 1 to control bit 8 zeroes the counter and leaves both capture registers unchanged.
- R11: While the run bit is 0, the output follows the initial-level bit. Reset leaves it at 0.
- R12: The register addresses are as follows:
  - 0: control, with bit 0 run, bit 1 source, bits 3:2 capture mode, bit 4 capture-0 toggle enable, bit 5 capture-1 toggle enable, bit 6 initial level, and bit 8 clear (write-only).
  - 1: compare.
  - 2: counter (read-only).
  - 3: capture 0 (read-only).
  - 4: capture 1 (read-only).

  Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaler tick, one count step per high cycle |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| trig_pin_i | input | 1 | External trigger pin (asynchronous) |
| gate_i | input | 1 | Gate from companion interval timer (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |
| tmr_out_o | output | 1 | Output flip-flop |
| cap0_o | output | 16 | Capture register 0 |
| cap1_o | output | 16 | Capture register 1 |
| irq_cmp_o | output | 1 | Compare-match pulse |
| irq_cap0_o | output | 1 | Capture-0 pulse |
| irq_cap1_o | output | 1 | Capture-1 pulse |

## Verification
Counting is tried with prescaler ticks and with count-pin pulses while the unused source toggles, which shows whether the source selection really gates each input. Gate windows are tried both inside the count range and straddling the 0xFFFF wrap, which separates a correct modulo difference from a saturating or reset-on-overflow counter. Trigger edges are applied under every capture mode, so rise-only, both-edge and disabled decoding can be told apart. The one-shot run measures the pulse width in count steps with the capture toggles both on and off, which exposes a missing or extra inversion.

// File: rtl/dcap_pkg.sv
package dcap_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP0 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP1 = 3'd4;

  localparam int unsigned CLR_BIT = 8;

  typedef enum logic [1:0] {
    CAP_OFF       = 2'b00,
    CAP_TRIG_BOTH = 2'b01,
    CAP_TRIG_RISE = 2'b10,
    CAP_GATE      = 2'b11
  } cap_mode_e;

  // packed msb first: init_lvl is bit 6, run is bit 0
  typedef struct packed {
    logic      init_lvl;
    logic      tg1;
    logic      tg0;
    cap_mode_e mode;
    logic      src_ext;
    logic      run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // index of each asynchronous pin in the synchroniser bank
  localparam int unsigned PIN_CNT  = 0;
  localparam int unsigned PIN_TRIG = 1;
  localparam int unsigned PIN_GATE = 2;
  localparam int unsigned N_PINS   = 3;

endpackage

// File: rtl/dcap_sync.sv
module dcap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
  assign fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/dcap_regs.sv
module dcap_regs
  import dcap_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      cnt,
  input  logic [W-1:0]      cap0,
  input  logic [W-1:0]      cap1,
  output ctrl_t             ctrl,
  output logic [W-1:0]      cmp,
  output logic              clr,
  output logic [W-1:0]      rdata
);
  localparam int unsigned PAD_W = W - CTRL_W;

  logic wr_ctrl;
  assign wr_ctrl = wr && (addr == A_CTRL);
  assign clr     = wr_ctrl && wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      cmp  <= '0;
    end else if (wr) begin
      if (addr == A_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (addr == A_CMP)  cmp  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_CTRL:  rdata <= {{PAD_W{1'b0}}, ctrl};
        A_CMP:   rdata <= cmp;
        A_CNT:   rdata <= cnt;
        A_CAP0:  rdata <= cap0;
        A_CAP1:  rdata <= cap1;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dcap_counter.sv
module dcap_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         clr,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         match
);
  logic [W-1:0] cnt_inc;
  assign cnt_inc = cnt + 1'b1;

  // a match is the step that lands on the compare value
  assign match = step && !clr && (cnt_inc == cmp);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt_inc;
  end
endmodule

// File: rtl/dcap_capture.sv
module dcap_capture #(
  parameter int unsigned W     = 16,
  parameter int unsigned N_CAP = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CAP-1:0]          ev,
  input  logic [W-1:0]              cnt,
  output logic [N_CAP-1:0][W-1:0]   cap,
  output logic [N_CAP-1:0]          flag
);
  for (genvar i = 0; i < N_CAP; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        cap[i]  <= '0;
        flag[i] <= 1'b0;
      end else begin
        flag[i] <= ev[i];
        if (ev[i]) cap[i] <= cnt;
      end
    end
  end
endmodule

// File: rtl/dcap_timer.sv
module dcap_timer
  import dcap_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              trig_pin_i,
  input  logic              gate_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [W-1:0]      reg_wdata_i,
  output logic [W-1:0]      reg_rdata_o,
  output logic              tmr_out_o,
  output logic [W-1:0]      cap0_o,
  output logic [W-1:0]      cap1_o,
  output logic              irq_cmp_o,
  output logic              irq_cap0_o,
  output logic              irq_cap1_o
);
  localparam int unsigned N_CAP = 2;

  ctrl_t                  ctrl;
  logic [W-1:0]           cmp_val;
  logic                   clr_pulse;
  logic [W-1:0]           cnt_val;
  logic                   cnt_step;
  logic                   cmp_hit;
  logic [N_PINS-1:0]      pin_raw;
  logic [N_PINS-1:0]      pin_rise;
  logic [N_PINS-1:0]      pin_fall;
  logic [N_CAP-1:0]       cap_ev;
  logic [N_CAP-1:0][W-1:0] cap_val;
  logic [N_CAP-1:0]       cap_flag;
  logic                   out_flip;
  logic                   out_q;

  assign pin_raw[PIN_CNT]  = cnt_pin_i;
  assign pin_raw[PIN_TRIG] = trig_pin_i;
  assign pin_raw[PIN_GATE] = gate_i;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    dcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (pin_raw[p]),
      .rise (pin_rise[p]),
      .fall (pin_fall[p])
    );
  end

  dcap_regs #(.W(W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr_i),
    .addr  (reg_addr_i),
    .wdata (reg_wdata_i),
    .cnt   (cnt_val),
    .cap0  (cap_val[0]),
    .cap1  (cap_val[1]),
    .ctrl  (ctrl),
    .cmp   (cmp_val),
    .clr   (clr_pulse),
    .rdata (reg_rdata_o)
  );

  assign cnt_step = ctrl.run && (ctrl.src_ext ? pin_rise[PIN_CNT] : tick_i);

  dcap_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (cnt_step),
    .clr   (clr_pulse),
    .cmp   (cmp_val),
    .cnt   (cnt_val),
    .match (cmp_hit)
  );

  always_comb begin
    cap_ev = '0;
    unique case (ctrl.mode)
      CAP_OFF:       cap_ev = '0;
      CAP_TRIG_BOTH: cap_ev = {pin_fall[PIN_TRIG], pin_rise[PIN_TRIG]};
      CAP_TRIG_RISE: cap_ev = {1'b0, pin_rise[PIN_TRIG]};
      CAP_GATE:      cap_ev = {pin_fall[PIN_GATE], pin_rise[PIN_GATE]};
      default:       cap_ev = '0;
    endcase
  end

  dcap_capture #(.W(W), .N_CAP(N_CAP)) u_cap (
    .clk  (clk),
    .rst  (rst),
    .ev   (cap_ev),
    .cnt  (cnt_val),
    .cap  (cap_val),
    .flag (cap_flag)
  );

  // simultaneous sources combine as parity
  assign out_flip = cmp_hit ^ (cap_ev[0] & ctrl.tg0) ^ (cap_ev[1] & ctrl.tg1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= 1'b0;
      irq_cmp_o <= 1'b0;
    end else begin
      irq_cmp_o <= cmp_hit;
      if (!ctrl.run)     out_q <= ctrl.init_lvl;
      else if (out_flip) out_q <= ~out_q;
    end
  end

  assign tmr_out_o  = out_q;
  assign cap0_o     = cap_val[0];
  assign cap1_o     = cap_val[1];
  assign irq_cap0_o = cap_flag[0];
  assign irq_cap1_o = cap_flag[1];
endmodule

// File: rtl/dcap_timer_chk.sv
module dcap_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         src_ext,
  input logic [1:0]   mode,
  input logic         tg0,
  input logic         tg1,
  input logic         init_lvl,
  input logic [W-1:0] cnt,
  input logic         step,
  input logic         clr,
  input logic         hit,
  input logic [1:0]   ev,
  input logic [2:0]   pin_fall,
  input logic         out,
  input logic         irq_cmp,
  input logic         irq_cap0,
  input logic         irq_cap1,
  input logic [W-1:0] cap0,
  input logic [W-1:0] cap1
);
  // R1
  a_r1_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (step && !clr) |=> (cnt == $past(cnt) + 1'b1));
  a_r1_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt));
  // R2: a falling count-pin edge alone never advances the counter
  a_r2_no_fall_step: assert property (@(posedge clk) disable iff (rst)
    (run && src_ext && pin_fall[0] && !clr) |=> $stable(cnt));
  // R3
  a_r3_cap0_value: assert property (@(posedge clk) disable iff (rst)
    ev[0] |=> (cap0 == $past(cnt)) && irq_cap0);
  a_r3_cap1_value: assert property (@(posedge clk) disable iff (rst)
    ev[1] |=> (cap1 == $past(cnt)) && irq_cap1);
  // R5
  a_r5_mode_off: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (!irq_cap0 && !irq_cap1 && $stable(cap0) && $stable(cap1)));
  // R6
  a_r6_cmp_flip: assert property (@(posedge clk) disable iff (rst)
    (run && hit && !(ev[0] && tg0) && !(ev[1] && tg1)) |=> (out != $past(out)) && irq_cmp);
  // R7
  a_r7_cap_quiet: assert property (@(posedge clk) disable iff (rst)
    (run && !hit && !(ev[0] && tg0) && !(ev[1] && tg1)) |=> $stable(out));
  // R9
  a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && cnt == {W{1'b1}}) |=> (cnt == '0));
  // R10
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && ev == 2'b00) |=> (cnt == '0) && $stable(cap0) && $stable(cap1));
  // R11
  a_r11_init_level: assert property (@(posedge clk) disable iff (rst)
    !run |=> (out == $past(init_lvl)));
endmodule

bind dcap_timer dcap_timer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (ctrl.run),
  .src_ext  (ctrl.src_ext),
  .mode     (ctrl.mode),
  .tg0      (ctrl.tg0),
  .tg1      (ctrl.tg1),
  .init_lvl (ctrl.init_lvl),
  .cnt      (cnt_val),
  .step     (cnt_step),
  .clr      (clr_pulse),
  .hit      (cmp_hit),
  .ev       (cap_ev),
  .pin_fall (pin_fall),
  .out      (tmr_out_o),
  .irq_cmp  (irq_cmp_o),
  .irq_cap0 (irq_cap0_o),
  .irq_cap1 (irq_cap1_o),
  .cap0     (cap0_o),
  .cap1     (cap1_o)
);

// File: tb/dcap_timer_tb.sv
module dcap_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0, cnt_pin_i = 1'b0, trig_pin_i = 1'b0, gate_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd0;
  logic [15:0] reg_wdata_i = 16'd0;
  logic [15:0] reg_rdata_o, cap0_o, cap1_o;
  logic        tmr_out_o, irq_cmp_o, irq_cap0_o, irq_cap1_o;

  int checks = 0, errors = 0, ncmp = 0;
  logic [15:0] exp0_q[$], exp1_q[$];
  string       tag0_q[$], tag1_q[$];

  always #2.5 clk = ~clk;

  dcap_timer u_dut (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  // scoreboard monitor: captures are matched against queued expectations
  always @(negedge clk) if (!rst) begin
    if (irq_cmp_o) ncmp++;
    if (irq_cap0_o) begin
      if (exp0_q.size() == 0) chk("R5 unexpected capture 0", 16'd1, 16'd0);
      else chk(tag0_q.pop_front(), cap0_o, exp0_q.pop_front());
    end
    if (irq_cap1_o) begin
      if (exp1_q.size() == 0) chk("R5 unexpected capture 1", 16'd1, 16'd0);
      else chk(tag1_q.pop_front(), cap1_o, exp1_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr_i = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata_o;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic push0(input string t, input logic [15:0] v);
    tag0_q.push_back(t); exp0_q.push_back(v);
  endtask

  task automatic push1(input string t, input logic [15:0] v);
    tag1_q.push_back(t); exp1_q.push_back(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, c0, c1;
    int width;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset output", {15'd0, tmr_out_o}, 16'd0);
    chk("R3 reset flags", {13'd0, irq_cmp_o, irq_cap0_o, irq_cap1_o}, 16'd0);
    rd(3'd2, d); chk("R1 reset count", d, 16'd0);

    wr(3'd1, 16'h1234); rd(3'd1, d); chk("R12 compare readback", d, 16'h1234);
    wr(3'd0, 16'h0005); rd(3'd0, d); chk("R12 control readback", d, 16'h0005);

    wr(3'd0, 16'h0001); ticks(10); rd(3'd2, d); chk("R1 count ten ticks", d, 16'd10);
    wr(3'd0, 16'h0000); ticks(3);  rd(3'd2, d); chk("R1 hold while stopped", d, 16'd10);

    wr(3'd0, 16'h0003); ticks(4); rd(3'd2, d); chk("R2 tick ignored on pin source", d, 16'd10);
    for (int i = 0; i < 5; i++) begin
      cnt_pin_i = 1'b1; repeat (3) @(negedge clk);
      cnt_pin_i = 1'b0; repeat (3) @(negedge clk);
    end
    settle(); rd(3'd2, d); chk("R2 pin pulses counted", d, 16'd15);

    wr(3'd0, 16'h0101); rd(3'd2, d); chk("R10 clear zeroes count", d, 16'd0);

    wr(3'd0, 16'h000D); ticks(7);
    push0("R3 gate rise capture", 16'd7); gate_i = 1'b1; settle();
    ticks(100);
    push1("R3 gate fall capture", 16'd107); gate_i = 1'b0; settle();
    rd(3'd3, c0); rd(3'd4, c1);
    chk("R3 capture0 readback", c0, 16'd7);
    chk("R3 difference", c1 - c0, 16'd100);

    wr(3'd0, 16'h010D); rd(3'd2, d); chk("R10 count cleared", d, 16'd0);
    chk("R10 capture0 kept", cap0_o, 16'd7);
    chk("R10 capture1 kept", cap1_o, 16'd107);

    wr(3'd0, 16'h0001);
    gate_i = 1'b1; settle(); gate_i = 1'b0; settle();
    trig_pin_i = 1'b1; settle(); trig_pin_i = 1'b0; settle();
    chk("R5 capture0 unchanged", cap0_o, 16'd7);
    chk("R5 capture1 unchanged", cap1_o, 16'd107);

    wr(3'd0, 16'h0005); ticks(3);
    push0("R4 trig rise capture", 16'd3); trig_pin_i = 1'b1; settle();
    ticks(2);
    push1("R4 trig fall capture", 16'd5); trig_pin_i = 1'b0; settle();
    wr(3'd0, 16'h0009); ticks(4);
    push0("R4 rise-only capture", 16'd9); trig_pin_i = 1'b1; settle();
    ticks(1); trig_pin_i = 1'b0; settle();
    chk("R4 rise-only keeps capture1", cap1_o, 16'd5);

    wr(3'd0, 16'h010D); ticks(65530);
    push0("R9 capture before wrap", 16'd65530); gate_i = 1'b1; settle();
    ticks(106);
    push1("R9 capture after wrap", 16'd100); gate_i = 1'b0; settle();
    chk("R9 wrapped difference", cap1_o - cap0_o, 16'd106);

    wr(3'd0, 16'h0000); @(negedge clk);
    chk("R11 stopped init low", {15'd0, tmr_out_o}, 16'd0);
    wr(3'd0, 16'h0040); @(negedge clk);
    chk("R11 stopped init high", {15'd0, tmr_out_o}, 16'd1);
    wr(3'd0, 16'h0000); @(negedge clk);
    chk("R11 back to low", {15'd0, tmr_out_o}, 16'd0);

    wr(3'd1, 16'd20); wr(3'd0, 16'h0100); wr(3'd0, 16'h0019); ticks(5);
    push0("R8 trigger capture", 16'd5); trig_pin_i = 1'b1; settle();
    chk("R7 capture0 toggles output", {15'd0, tmr_out_o}, 16'd1);
    d = 16'(ncmp); width = 0;
    for (int k = 0; k < 40; k++) begin
      if (tmr_out_o == 1'b0) break;
      ticks(1); width++;
    end
    @(negedge clk);
    chk("R8 pulse width", 16'(width), 16'd15);
    chk("R6 one compare pulse", 16'(ncmp), d + 16'd1);
    rd(3'd2, d); chk("R6 count at compare", d, 16'd20);
    trig_pin_i = 1'b0; settle();
    chk("R8 output stays low", {15'd0, tmr_out_o}, 16'd0);

    wr(3'd0, 16'h0005); ticks(2);
    push0("R7 capture0 no toggle", 16'd22); trig_pin_i = 1'b1; settle();
    chk("R7 disabled capture0 keeps output", {15'd0, tmr_out_o}, 16'd0);
    push1("R7 capture1 no toggle", 16'd22); trig_pin_i = 1'b0; settle();
    chk("R7 disabled capture1 keeps output", {15'd0, tmr_out_o}, 16'd0);
    wr(3'd0, 16'h0025);
    push0("R7 capture0 again", 16'd22); trig_pin_i = 1'b1; settle();
    chk("R7 capture0 still off", {15'd0, tmr_out_o}, 16'd0);
    push1("R7 capture1 toggle", 16'd22); trig_pin_i = 1'b0; settle();
    chk("R7 capture1 toggles output", {15'd0, tmr_out_o}, 16'd1);

    chk("R3 all expected captures seen", 16'(exp0_q.size() + exp1_q.size()), 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule